// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Front-End

This block is the control/status register file that sits in front of a group of DMA channel engines. A 32-bit register bus reaches it, and each channel has its own 8 KiB address window. For every channel the block holds four pointer registers, a configuration register, a command register, an interrupt mask and a stream-command register. It also keeps the raw interrupt bits, which the engine raises and software acknowledges.

The block drives one level-sensitive interrupt line per channel. It also drives the enable and stop qualifiers and the pointer values. It decodes register writes into one-cycle request pulses for the engine: load a data descriptor, start, load a context, and run the continue check. The engine's live state, end-of-list flag and stream source are folded into a status word that software can read. Data movement and descriptor fetching stay in the engine.

The bus takes one request per cycle and answers it on the following cycle with a response strobe, read data and an error flag.

Top module: `dmafe_top`

## Requirements
- R1: Only 32-bit accesses are legal (`bus_size` = 2). The response to a byte (0), halfword (1) or reserved (3) access has `bus_err` set and `bus_rdata` zero, and the access changes no register.
- R2: Every request gets exactly one response, with `bus_rsp` high in the cycle after the request. A write returns `bus_rdata` zero.
- R3: These registers read back the last value written, and their values drive the matching pointer outputs: data-descriptor pointer at offset 0x58, buffer position at 0x5C, group pointer at 0x60, group-down pointer at 0x7C, command at 0x80, configuration at 0x84 and stream command at 0x9C.
- R4: Address bits 12:0 are the offset within a channel. The bits above them select the channel. A write to one channel leaves every other channel's registers unchanged.
- R5: `ch_enable` is configuration bit 0 AND `client_attached` for that channel. `ch_stop` is configuration bit 1.
- R6: A pulse on an `intr_set` bit sets that raw interrupt bit (readable at 0x94), and the bit stays set until acknowledged. Writing the acknowledge register (0x90) clears the raw bits that are 1 in the written value. A set in the same cycle as its acknowledge wins.
- R7: The acknowledge register always reads as zero.
- R8: The mask register (0x8C, bits 3:0) reads back. The masked register (0x98) reads raw AND mask. `irq` is high exactly when that value is nonzero, and it follows a mask write or an acknowledge write in the same cycle as the register update.
- R9: The status register (0x88) reads the engine state in bits 2:0, the end-of-list flag in bit 5 and the stream source from bit 8 upward. All other bits are zero.
- R10: A stream-command write uses bits 9:0 only. `req_load_d` pulses for one cycle, in the cycle after the write, if bit 6 or bit 8 is set. `req_start` pulses with it if bit 5 is also set. `req_load_c` pulses if bit 9 is set. Bit 5 alone, and any bit above 9, requests nothing.
- R11: Each write to the command register gives a one-cycle `req_continue` pulse in the cycle after the write.
- R12: After reset every register reads zero, `irq` is low, and no request pulse is active.
- R13: Offsets not listed above read as zero, and writes to them have no effect. The status, raw and masked registers are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Request valid for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte address: channel in bits 13 and up, offset in bits 12:0 |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_wdata | input | 32 | Write data |
| bus_rsp | output | 1 | Response strobe, one cycle after the request |
| bus_rdata | output | 32 | Read data for the response |
| bus_err | output | 1 | Illegal access size |
| client_attached | input | NCH | A client is attached to the channel |
| eng_state | input | 3*NCH | Engine state code per channel |
| eng_eol | input | NCH | Engine end-of-list flag per channel |
| eng_src | input | SRC_W*NCH | Stream-command source per channel |
| intr_set | input | 4*NCH | Raw interrupt set pulses |
| ch_enable | output | NCH | Qualified enable |
| ch_stop | output | NCH | Stop request |
| ptr_data | output | 32*NCH | Data-descriptor pointer |
| ptr_buf | output | 32*NCH | Buffer position |
| ptr_grp | output | 32*NCH | Group pointer |
| ptr_gdown | output | 32*NCH | Group-down pointer |
| req_load_d | output | NCH | Load data descriptor pulse |
| req_start | output | NCH | Start pulse |
| req_load_c | output | NCH | Load context pulse |
| req_continue | output | NCH | Continue-check pulse |
| irq | output | NCH | Level interrupt per channel |

## Verification
The stream-command decode is checked with single-bit and combined codes. Bit 6 alone and bit 8 alone each give a load without a start, which shows that either bit is enough. Bit 6 with bit 5 adds the start. Bit 5 alone gives nothing, which shows the start depends on the load. A value with only bit 10 set shows the upper bits are ignored.

The interrupt path is checked with overlapping raw and mask patterns, so that the raw and masked reads differ. It is also checked with a partial acknowledge, with a mask write that raises the line on its own, and with a set that coincides with its acknowledge.

The register path is checked with distinct values per channel, which separates the channel decode from the offset decode. Illegal sizes are tried against a register that already holds a value, to show that the access has no effect.

// File: rtl/dmafe_pkg.sv
package dmafe_pkg;

    localparam int WIN_BITS = 13;
    localparam int INTR_W   = 4;

    localparam logic [1:0] SIZE_WORD = 2'd2;

    localparam logic [12:0] OFF_DPTR  = 13'h058;
    localparam logic [12:0] OFF_BPTR  = 13'h05C;
    localparam logic [12:0] OFF_GRP   = 13'h060;
    localparam logic [12:0] OFF_GDOWN = 13'h07C;
    localparam logic [12:0] OFF_CMD   = 13'h080;
    localparam logic [12:0] OFF_CFG   = 13'h084;
    localparam logic [12:0] OFF_STAT  = 13'h088;
    localparam logic [12:0] OFF_MASK  = 13'h08C;
    localparam logic [12:0] OFF_ACK   = 13'h090;
    localparam logic [12:0] OFF_RAW   = 13'h094;
    localparam logic [12:0] OFF_MSKD  = 13'h098;
    localparam logic [12:0] OFF_SCMD  = 13'h09C;

    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_STOP_BIT = 1;

    localparam logic [9:0] SC_LOAD_D = 10'h140;
    localparam logic [9:0] SC_START  = 10'h020;
    localparam logic [9:0] SC_LOAD_C = 10'h200;

    typedef struct packed {
        logic load_d;
        logic start;
        logic load_c;
    } scmd_req_t;

    function automatic scmd_req_t scmd_decode(input logic [31:0] v);
        scmd_req_t r;
        logic [9:0] c;
        c        = v[9:0];
        r.load_d = |(c & SC_LOAD_D);
        r.start  = r.load_d && |(c & SC_START);
        r.load_c = |(c & SC_LOAD_C);
        return r;
    endfunction

endpackage

// File: rtl/dmafe_scmd.sv
module dmafe_scmd
    import dmafe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe,
    input  logic [31:0] value,
    output logic        load_d,
    output logic        start,
    output logic        load_c
);

    scmd_req_t dec, req_q;

    always_comb dec = scmd_decode(value);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (strobe) begin
            req_q <= dec;
        end else begin
            req_q <= '0;
        end
    end

    assign load_d = req_q.load_d;
    assign start  = req_q.start;
    assign load_c = req_q.load_c;

    // R10: start is only ever issued together with a descriptor load
    assert_start_needs_load_R10: assert property (@(posedge clk) disable iff (rst)
        start |-> load_d);

    // R10: a context load follows a write that carried bit 9
    assert_load_c_source_R10: assert property (@(posedge clk) disable iff (rst)
        load_c |-> $past(strobe && value[9]));

    // R10: request pulses last one cycle when no new write follows
    assert_pulse_width_R10: assert property (@(posedge clk) disable iff (rst)
        (load_d && !strobe) |=> !load_d);

endmodule

// File: rtl/dmafe_chan.sv
module dmafe_chan
    import dmafe_pkg::*;
#(
    parameter int SRC_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [12:0]       off,
    input  logic [31:0]       wdata,
    input  logic              client_attached,
    input  logic [2:0]        eng_state,
    input  logic              eng_eol,
    input  logic [SRC_W-1:0]  eng_src,
    input  logic [INTR_W-1:0] intr_set,
    output logic [31:0]       rd_data,
    output logic              ch_enable,
    output logic              ch_stop,
    output logic [31:0]       ptr_data,
    output logic [31:0]       ptr_buf,
    output logic [31:0]       ptr_grp,
    output logic [31:0]       ptr_gdown,
    output logic              req_load_d,
    output logic              req_start,
    output logic              req_load_c,
    output logic              req_continue,
    output logic              irq
);

    localparam int STAT_PAD = 32 - 8 - SRC_W;
    localparam int INTR_PAD = 32 - INTR_W;

    logic [31:0] dptr_q, bptr_q, grp_q, gdown_q, cmd_q, cfg_q, scmd_q;
    logic [INTR_W-1:0] mask_q, raw_q, raw_n, ack_bits, masked;
    logic wr_cmd, wr_scmd, wr_ack, wr_mask, cont_q;

    assign wr_cmd  = wr_en && (off == OFF_CMD);
    assign wr_scmd = wr_en && (off == OFF_SCMD);
    assign wr_ack  = wr_en && (off == OFF_ACK);
    assign wr_mask = wr_en && (off == OFF_MASK);

    assign ack_bits = wr_ack ? wdata[INTR_W-1:0] : '0;
    assign raw_n    = (raw_q & ~ack_bits) | intr_set;
    assign masked   = raw_q & mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dptr_q  <= '0;
            bptr_q  <= '0;
            grp_q   <= '0;
            gdown_q <= '0;
            cmd_q   <= '0;
            cfg_q   <= '0;
            scmd_q  <= '0;
            mask_q  <= '0;
            raw_q   <= '0;
            cont_q  <= 1'b0;
        end else begin
            raw_q  <= raw_n;
            cont_q <= wr_cmd;
            if (wr_en) begin
                case (off)
                    OFF_DPTR:  dptr_q  <= wdata;
                    OFF_BPTR:  bptr_q  <= wdata;
                    OFF_GRP:   grp_q   <= wdata;
                    OFF_GDOWN: gdown_q <= wdata;
                    OFF_CMD:   cmd_q   <= wdata;
                    OFF_CFG:   cfg_q   <= wdata;
                    OFF_SCMD:  scmd_q  <= wdata;
                    OFF_MASK:  mask_q  <= wdata[INTR_W-1:0];
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        case (off)
            OFF_DPTR:  rd_data = dptr_q;
            OFF_BPTR:  rd_data = bptr_q;
            OFF_GRP:   rd_data = grp_q;
            OFF_GDOWN: rd_data = gdown_q;
            OFF_CMD:   rd_data = cmd_q;
            OFF_CFG:   rd_data = cfg_q;
            OFF_SCMD:  rd_data = scmd_q;
            OFF_STAT:  rd_data = {{STAT_PAD{1'b0}}, eng_src, 2'b00, eng_eol, 2'b00, eng_state};
            OFF_MASK:  rd_data = {{INTR_PAD{1'b0}}, mask_q};
            OFF_RAW:   rd_data = {{INTR_PAD{1'b0}}, raw_q};
            OFF_MSKD:  rd_data = {{INTR_PAD{1'b0}}, masked};
            default:   rd_data = '0;
        endcase
    end

    assign ch_enable    = cfg_q[CFG_EN_BIT] && client_attached;
    assign ch_stop      = cfg_q[CFG_STOP_BIT];
    assign ptr_data     = dptr_q;
    assign ptr_buf      = bptr_q;
    assign ptr_grp      = grp_q;
    assign ptr_gdown    = gdown_q;
    assign req_continue = cont_q;
    assign irq          = |masked;

    dmafe_scmd u_scmd (
        .clk    (clk),
        .rst    (rst),
        .strobe (wr_scmd),
        .value  (wdata),
        .load_d (req_load_d),
        .start  (req_start),
        .load_c (req_load_c)
    );

    // R6: acknowledged bits are clear afterwards unless re-raised
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && intr_set == '0) |=> ((raw_q & $past(wdata[INTR_W-1:0])) == '0));

    // R6: a raw bit holds until acknowledged
    assert_raw_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (raw_q != '0 && !wr_ack) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

    // R8: the line only rises after an interrupt event or a mask change
    assert_irq_rise_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(intr_set != '0 || wr_mask));

    // R11: continue pulse traces back to a command write
    assert_continue_src_R11: assert property (@(posedge clk) disable iff (rst)
        req_continue |-> $past(wr_cmd));

endmodule

// File: rtl/dmafe_top.sv
module dmafe_top
    import dmafe_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int SRC_W = 2,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int AW   = WIN_BITS + CH_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_req,
    input  logic                  bus_we,
    input  logic [AW-1:0]         bus_addr,
    input  logic [1:0]            bus_size,
    input  logic [31:0]           bus_wdata,
    output logic                  bus_rsp,
    output logic [31:0]           bus_rdata,
    output logic                  bus_err,
    input  logic [NCH-1:0]        client_attached,
    input  logic [3*NCH-1:0]      eng_state,
    input  logic [NCH-1:0]        eng_eol,
    input  logic [SRC_W*NCH-1:0]  eng_src,
    input  logic [INTR_W*NCH-1:0] intr_set,
    output logic [NCH-1:0]        ch_enable,
    output logic [NCH-1:0]        ch_stop,
    output logic [32*NCH-1:0]     ptr_data,
    output logic [32*NCH-1:0]     ptr_buf,
    output logic [32*NCH-1:0]     ptr_grp,
    output logic [32*NCH-1:0]     ptr_gdown,
    output logic [NCH-1:0]        req_load_d,
    output logic [NCH-1:0]        req_start,
    output logic [NCH-1:0]        req_load_c,
    output logic [NCH-1:0]        req_continue,
    output logic [NCH-1:0]        irq
);

    logic [CH_W-1:0] ch_sel;
    logic [12:0]     off;
    logic            size_ok;
    logic [31:0]     chan_rd [NCH];

    assign ch_sel  = bus_addr[AW-1:WIN_BITS];
    assign off     = {bus_addr[12:2], 2'b00};
    assign size_ok = (bus_size == SIZE_WORD);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic wr_hit;
        assign wr_hit = bus_req && bus_we && size_ok && (ch_sel == CH_W'(g));

        dmafe_chan #(.SRC_W(SRC_W)) u_chan (
            .clk             (clk),
            .rst             (rst),
            .wr_en           (wr_hit),
            .off             (off),
            .wdata           (bus_wdata),
            .client_attached (client_attached[g]),
            .eng_state       (eng_state[3*g +: 3]),
            .eng_eol         (eng_eol[g]),
            .eng_src         (eng_src[SRC_W*g +: SRC_W]),
            .intr_set        (intr_set[INTR_W*g +: INTR_W]),
            .rd_data         (chan_rd[g]),
            .ch_enable       (ch_enable[g]),
            .ch_stop         (ch_stop[g]),
            .ptr_data        (ptr_data[32*g +: 32]),
            .ptr_buf         (ptr_buf[32*g +: 32]),
            .ptr_grp         (ptr_grp[32*g +: 32]),
            .ptr_gdown       (ptr_gdown[32*g +: 32]),
            .req_load_d      (req_load_d[g]),
            .req_start       (req_start[g]),
            .req_load_c      (req_load_c[g]),
            .req_continue    (req_continue[g]),
            .irq             (irq[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rsp   <= 1'b0;
            bus_err   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_rsp   <= bus_req;
            bus_err   <= bus_req && !size_ok;
            bus_rdata <= (bus_req && !bus_we && size_ok) ? chan_rd[ch_sel] : '0;
        end
    end

    // R1: an error response carries no data
    assert_err_no_data_R1: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (bus_rdata == '0));

    // R2: every response follows a request one cycle earlier
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        bus_rsp |-> $past(bus_req));

    // R2: every request is answered on the next cycle
    assert_req_answered_R2: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> bus_rsp);

endmodule

// File: tb/dmafe_top_tb_top.sv
module dmafe_top_tb_top;

    localparam int NCH = 2;
    localparam int SRC_W = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_req = 1'b0, bus_we = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic bus_rsp, bus_err;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] client_attached = '0;
    logic [3*NCH-1:0] eng_state = '0;
    logic [NCH-1:0] eng_eol = '0;
    logic [SRC_W*NCH-1:0] eng_src = '0;
    logic [4*NCH-1:0] intr_set = '0;
    logic [NCH-1:0] ch_enable, ch_stop, req_load_d, req_start, req_load_c, req_continue, irq;
    logic [32*NCH-1:0] ptr_data, ptr_buf, ptr_grp, ptr_gdown;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dmafe_top #(.NCH(NCH), .SRC_W(SRC_W)) dut_i (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rsp(bus_rsp), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .client_attached(client_attached), .eng_state(eng_state),
        .eng_eol(eng_eol), .eng_src(eng_src), .intr_set(intr_set), .ch_enable(ch_enable),
        .ch_stop(ch_stop), .ptr_data(ptr_data), .ptr_buf(ptr_buf), .ptr_grp(ptr_grp),
        .ptr_gdown(ptr_gdown), .req_load_d(req_load_d), .req_start(req_start),
        .req_load_c(req_load_c), .req_continue(req_continue), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus cycle; returns at the negedge where the response is visible
    task automatic access(input bit we, input int ch, input logic [12:0] off,
                          input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = {ch[0], off}; bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_size = 2'd2;
    endtask

    task automatic wr(input int ch, input logic [12:0] off, input logic [31:0] d);
        access(1'b1, ch, off, d, 2'd2);
    endtask

    task automatic rd_chk(input string req, input int ch, input logic [12:0] off,
                          input logic [31:0] exp);
        access(1'b0, ch, off, 32'h0, 2'd2);
        check(req, {31'b0, bus_rsp}, 32'h1);
        check(req, bus_rdata, exp);
    endtask

    task automatic t_reset();
        check("R12 irq", {30'b0, irq}, 32'h0);
        check("R12 pulses", {24'b0, req_load_d, req_start, req_load_c, req_continue}, 32'h0);
        rd_chk("R12 dptr", 0, 13'h058, 32'h0);
        rd_chk("R12 cfg", 1, 13'h084, 32'h0);
        rd_chk("R12 mask", 0, 13'h08C, 32'h0);
        rd_chk("R12 raw", 1, 13'h094, 32'h0);
    endtask

    task automatic t_regs();
        wr(0, 13'h058, 32'h1000_0040);
        check("R2 write rsp", {31'b0, bus_rsp}, 32'h1);
        check("R2 write rdata", bus_rdata, 32'h0);
        wr(0, 13'h05C, 32'h1000_0080);
        wr(0, 13'h060, 32'h2000_0000);
        wr(0, 13'h07C, 32'h3000_0010);
        wr(1, 13'h058, 32'hCAFE_0004);
        rd_chk("R3 dptr", 0, 13'h058, 32'h1000_0040);
        rd_chk("R3 bptr", 0, 13'h05C, 32'h1000_0080);
        rd_chk("R3 grp", 0, 13'h060, 32'h2000_0000);
        rd_chk("R3 gdown", 0, 13'h07C, 32'h3000_0010);
        check("R3 ptr_buf out", ptr_buf[31:0], 32'h1000_0080);
        check("R3 ptr_gdown out", ptr_gdown[31:0], 32'h3000_0010);
        rd_chk("R4 ch1 dptr", 1, 13'h058, 32'hCAFE_0004);
        check("R4 ptr_data ch0", ptr_data[31:0], 32'h1000_0040);
        check("R4 ptr_data ch1", ptr_data[63:32], 32'hCAFE_0004);
        rd_chk("R4 ch1 bptr untouched", 1, 13'h05C, 32'h0);
    endtask

    task automatic t_cfg();
        wr(0, 13'h084, 32'h1);
        check("R5 en no client", {31'b0, ch_enable[0]}, 32'h0);
        client_attached = 2'b01;
        #1 check("R5 en with client", {31'b0, ch_enable[0]}, 32'h1);
        wr(0, 13'h084, 32'h2);
        check("R5 stop", {30'b0, ch_stop}, 32'h1);
        check("R5 en cleared", {31'b0, ch_enable[0]}, 32'h0);
        rd_chk("R3 cfg", 0, 13'h084, 32'h2);
    endtask

    task automatic t_size();
        for (int s = 0; s < 4; s++) begin
            if (s == 2) continue;
            access(1'b1, 0, 13'h058, 32'hDEAD_BEEF, 2'(s));
            check("R1 err on write", {31'b0, bus_err}, 32'h1);
            access(1'b0, 0, 13'h058, 32'h0, 2'(s));
            check("R1 err on read", {31'b0, bus_err}, 32'h1);
            check("R1 no data", bus_rdata, 32'h0);
        end
        rd_chk("R1 register unchanged", 0, 13'h058, 32'h1000_0040);
        check("R1 legal no err", {31'b0, bus_err}, 32'h0);
    endtask

    task automatic t_irq();
        wr(0, 13'h08C, 32'h5);
        @(negedge clk) intr_set[3:0] = 4'b0110;
        @(negedge clk) intr_set[3:0] = 4'b0000;
        check("R8 irq raised", {30'b0, irq}, 32'h1);
        rd_chk("R6 raw", 0, 13'h094, 32'h6);
        rd_chk("R8 masked", 0, 13'h098, 32'h4);
        rd_chk("R8 mask readback", 0, 13'h08C, 32'h5);
        wr(0, 13'h090, 32'h4);
        check("R8 irq low after ack", {30'b0, irq}, 32'h0);
        rd_chk("R6 partial ack", 0, 13'h094, 32'h2);
        rd_chk("R7 ack reads zero", 0, 13'h090, 32'h0);
        wr(0, 13'h08C, 32'h2);
        check("R8 irq via mask", {30'b0, irq}, 32'h1);
        // set and acknowledge of bit 0 in the same cycle
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = {1'b0, 13'h090}; bus_wdata = 32'h3;
        intr_set[3:0] = 4'b0001;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; intr_set[3:0] = 4'b0000;
        rd_chk("R6 set wins over ack", 0, 13'h094, 32'h1);
        check("R8 irq after clear", {30'b0, irq}, 32'h0);
        wr(0, 13'h094, 32'hF);
        rd_chk("R13 raw read-only", 0, 13'h094, 32'h1);
    endtask

    task automatic t_status();
        eng_state = {3'd4, 3'd2};
        eng_eol   = 2'b10;
        eng_src   = {2'd3, 2'd1};
        rd_chk("R9 status ch1", 1, 13'h088, 32'h0000_0324);
        rd_chk("R9 status ch0", 0, 13'h088, 32'h0000_0102);
        wr(1, 13'h088, 32'hFFFF_FFFF);
        rd_chk("R13 status read-only", 1, 13'h088, 32'h0000_0324);
    endtask

    task automatic scmd_case(input logic [31:0] v, input logic [2:0] exp);
        wr(1, 13'h09C, v);
        check($sformatf("R10 decode %h", v), {29'b0, req_load_d[1], req_start[1], req_load_c[1]},
              {29'b0, exp});
        check("R10 ch0 quiet", {29'b0, req_load_d[0], req_start[0], req_load_c[0]}, 32'h0);
        @(negedge clk);
        check("R10 one cycle", {29'b0, req_load_d[1], req_start[1], req_load_c[1]}, 32'h0);
    endtask

    task automatic t_stream();
        scmd_case(32'h040, 3'b100);
        scmd_case(32'h100, 3'b100);
        scmd_case(32'h060, 3'b110);
        scmd_case(32'h020, 3'b000);
        scmd_case(32'h200, 3'b001);
        scmd_case(32'h400, 3'b000);
        scmd_case(32'h360, 3'b111);
        rd_chk("R3 scmd readback", 1, 13'h09C, 32'h360);
    endtask

    task automatic t_continue();
        wr(1, 13'h080, 32'h1);
        check("R11 continue pulse", {30'b0, req_continue}, 32'h2);
        @(negedge clk);
        check("R11 pulse ends", {30'b0, req_continue}, 32'h0);
        rd_chk("R3 cmd", 1, 13'h080, 32'h1);
    endtask

    task automatic t_unmapped();
        wr(0, 13'h000, 32'h1234_5678);
        rd_chk("R13 data window zero", 0, 13'h000, 32'h0);
        wr(0, 13'h0A0, 32'hFFFF_FFFF);
        rd_chk("R13 unmapped zero", 0, 13'h0A0, 32'h0);
        wr(0, 13'h098, 32'hF);
        rd_chk("R13 masked read-only", 0, 13'h098, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_cfg();
        t_size();
        t_irq();
        t_status();
        t_stream();
        t_continue();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule